// File: doc/BRIEF.md
# Host-to-Coprocessor Byte Mailbox

This block sits between a byte-wide host bus and a coprocessor. The host sees eight byte registers. Offset 0 is a control register and offset 1 is a command register. Offset 2 is a read-only status register, offset 3 is a vector register, and offsets 4 to 7 are a four-byte data window. The bytes of the data window run from most significant (offset 4) to least significant (offset 7).

A word the host writes through the window goes to a host-side holding register. The next free cycle moves it into a coprocessor-side register, and the coprocessor takes it with a valid/ready strobe. Words from the coprocessor land in a receive register, which the host reads back through the same window.

Status flags tell the host when received data is waiting, when the holding register is free and when the whole transmit path is idle. The control register also sets two request enables for one interrupt line, two flags sent to the coprocessor and a two-bit mode. Writing the command register raises a command request that carries a five-bit vector. That request stays up until the coprocessor acknowledges it, and then it clears by itself.

Top module: `hostcop_mailbox`

## Requirements
- R1: After reset, control reads 0x00, command reads 0x00, status reads 0x06, the vector register reads 0x0F, `host_irq` and `dsp_tx_valid` are low and `dsp_rx_ready` is high.
- R2: Host writes to offsets 4, 5 and 6 fill the upper three bytes of an outgoing word and leave status unchanged. A write to offset 7 supplies the low byte and commits the word, so status bit 1 (transmit empty) reads 0 in the next cycle. The word is presented on `dsp_tx_data` as {off4, off5, off6, off7}.
- R3: A committed word moves to the coprocessor-side register in the first cycle in which that register is empty or is being taken, and status bit 1 then sets again. Status bit 2 (transmitter ready) is 1 only when status bit 1 is 1 and `dsp_tx_valid` is low. `dsp_tx_valid` and `dsp_tx_data` hold until `dsp_tx_ready` is seen.
- R4: A coprocessor word is accepted on a cycle with `dsp_rx_valid` high and `dsp_rx_ready` high. Acceptance sets status bit 0 (receive full) and drops `dsp_rx_ready`. While the receive register is full, offered words are ignored. The accepted word reads back as off4 = bits 31:24 down to off7 = bits 7:0.
- R5: A host read of offset 7 clears receive full. Reads of offsets 4 to 6 leave it set.
- R6: `host_irq` and status bit 7 equal (receive full AND control bit 0) OR (transmit empty AND control bit 1).
- R7: Control bits 4:3 drive `host_flags_out[1:0]`. `dsp_flags_in[1:0]` reads back as status bits 4:3.
- R8: Control bits 6:5 drive `host_mode`. Status bit 6 reads 1 whenever that mode is non-zero.
- R9: Writing the command register with bit 7 set, while no command is pending, latches bits 4:0 as the vector and raises `dsp_cmd_valid`. The command register reads {pending, 00, vector}. Writes to it while a command is pending are ignored, and so are writes with bit 7 clear. The pending flag clears in the cycle after `dsp_cmd_ack`.
- R10: A control write with bit 7 set empties both transmit registers and the receive register and cancels a pending command. Control bit 7 reads back 0.
- R11: The vector register at offset 3 reads back the last byte written and drives `irq_vector`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational from the offset |
| host_irq | output | 1 | Host interrupt request |
| irq_vector | output | 8 | Contents of the vector register |
| host_flags_out | output | 2 | Flags from host to coprocessor |
| host_mode | output | 2 | Host mode selection |
| dsp_flags_in | input | 2 | Flags from coprocessor to host |
| dsp_tx_valid | output | 1 | Word waiting for the coprocessor |
| dsp_tx_ready | input | 1 | Coprocessor takes the word |
| dsp_tx_data | output | 32 | Word to the coprocessor |
| dsp_rx_valid | input | 1 | Coprocessor offers a word |
| dsp_rx_ready | output | 1 | Receive register empty |
| dsp_rx_data | input | 32 | Word from the coprocessor |
| dsp_cmd_valid | output | 1 | Host command pending |
| dsp_cmd_vec | output | 5 | Command vector |
| dsp_cmd_ack | input | 1 | Coprocessor acknowledges the command |

## Verification
Every register update lands on the clock edge that ends the access or strobe cycle. Read data and status, by contrast, are combinational. A status read issued in the cycle right after a commit therefore still shows transmit empty low, and the same read issued one cycle later shows the move into the coprocessor register. The bench issues each read at the falling edge right after the stimulus edge and samples 1 ns later, before the next rising edge. It does the same for port-level results such as the interrupt and the command strobe, so each check sees the state exactly one edge after the stimulus. Back-to-back words are checked across the take edge, because the move and the take happen on the same edge.

// File: rtl/hostcop_mailbox.sv
module hostcop_mailbox #(
  parameter int WORD_W = 32,
  parameter int VEC_W = 5,
  parameter logic [7:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_irq,
  output logic [7:0]        irq_vector,
  output logic [1:0]        host_flags_out,
  output logic [1:0]        host_mode,
  input  logic [1:0]        dsp_flags_in,
  output logic              dsp_tx_valid,
  input  logic              dsp_tx_ready,
  output logic [WORD_W-1:0] dsp_tx_data,
  input  logic              dsp_rx_valid,
  output logic              dsp_rx_ready,
  input  logic [WORD_W-1:0] dsp_rx_data,
  output logic              dsp_cmd_valid,
  output logic [VEC_W-1:0]  dsp_cmd_vec,
  input  logic              dsp_cmd_ack
);
  localparam int NB = WORD_W / 8;

  logic wr, rd, init_wr;
  logic rx_ie, tx_ie;
  logic txh_full, crx_full, rxdf;
  logic take, move;
  logic [WORD_W-1:0] stage, hold, crx_data, rx_word;
  logic [7:0] status;

  assign wr      = host_cs && host_we;
  assign rd      = host_cs && !host_we;
  assign init_wr = wr && host_addr == 3'd0 && host_wdata[7];
  assign take    = crx_full && dsp_tx_ready;
  assign move    = txh_full && (!crx_full || take);

  assign dsp_tx_valid = crx_full;
  assign dsp_tx_data  = crx_data;
  assign dsp_rx_ready = !rxdf;
  assign host_irq     = (rxdf && rx_ie) || (!txh_full && tx_ie);
  assign status = {host_irq, |host_mode, 1'b0, dsp_flags_in,
                   !txh_full && !crx_full, !txh_full, rxdf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
      host_flags_out <= '0;
      host_mode <= '0;
      irq_vector <= VEC_RESET;
    end else begin
      if (wr && host_addr == 3'd0) begin
        rx_ie <= host_wdata[0];
        tx_ie <= host_wdata[1];
        host_flags_out <= host_wdata[4:3];
        host_mode <= host_wdata[6:5];
      end
      if (wr && host_addr == 3'd3) irq_vector <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_cmd_valid <= 1'b0;
      dsp_cmd_vec <= '0;
    end else if (init_wr) begin
      dsp_cmd_valid <= 1'b0;
    end else if (dsp_cmd_valid) begin
      if (dsp_cmd_ack) dsp_cmd_valid <= 1'b0;
    end else if (wr && host_addr == 3'd1 && host_wdata[7]) begin
      dsp_cmd_valid <= 1'b1;
      dsp_cmd_vec <= host_wdata[VEC_W-1:0];
    end
  end

  for (genvar b = 1; b < NB; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[8*b +: 8] <= '0;
      else if (wr && host_addr == 3'(8 - NB + (NB - 1 - b))) stage[8*b +: 8] <= host_wdata;
    end
  end
  assign stage[7:0] = host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txh_full <= 1'b0;
      crx_full <= 1'b0;
      hold <= '0;
      crx_data <= '0;
    end else if (init_wr) begin
      txh_full <= 1'b0;
      crx_full <= 1'b0;
    end else begin
      if (move) begin
        crx_data <= hold;
        crx_full <= 1'b1;
        txh_full <= 1'b0;
      end else if (take) begin
        crx_full <= 1'b0;
      end
      if (wr && host_addr == 3'd7) begin
        hold <= stage;
        txh_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxdf <= 1'b0;
      rx_word <= '0;
    end else if (init_wr) begin
      rxdf <= 1'b0;
    end else if (rxdf) begin
      if (rd && host_addr == 3'd7) rxdf <= 1'b0;
    end else if (dsp_rx_valid) begin
      rx_word <= dsp_rx_data;
      rxdf <= 1'b1;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      3'd0: host_rdata = {1'b0, host_mode, host_flags_out, 1'b0, tx_ie, rx_ie};
      3'd1: host_rdata = {dsp_cmd_valid, {(7-VEC_W){1'b0}}, dsp_cmd_vec};
      3'd2: host_rdata = status;
      3'd3: host_rdata = irq_vector;
      default: begin
        for (int b = 0; b < NB; b++)
          if (host_addr == 3'(7 - b)) host_rdata = rx_word[8*b +: 8];
      end
    endcase
  end
endmodule

// File: rtl/hostcop_mailbox_chk.sv
module hostcop_mailbox_chk #(
  parameter int WORD_W = 32,
  parameter int VEC_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs,
  input logic              host_we,
  input logic [2:0]        host_addr,
  input logic [7:0]        host_wdata,
  input logic              host_irq,
  input logic              rx_ie,
  input logic              txh_full,
  input logic              dsp_tx_valid,
  input logic              dsp_tx_ready,
  input logic [WORD_W-1:0] dsp_tx_data,
  input logic              dsp_rx_valid,
  input logic              dsp_rx_ready,
  input logic              dsp_cmd_valid,
  input logic [VEC_W-1:0]  dsp_cmd_vec,
  input logic              dsp_cmd_ack
);
  logic init_w, commit_w;
  assign init_w   = host_cs && host_we && host_addr == 3'd0 && host_wdata[7];
  assign commit_w = host_cs && host_we && host_addr == 3'd7;

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> txh_full);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_tx_valid && !dsp_tx_ready && !init_w |=> dsp_tx_valid && $stable(dsp_tx_data));

  assert_rx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_rx_valid && dsp_rx_ready && !init_w |=> !dsp_rx_ready);

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ie && !dsp_rx_ready |-> host_irq);

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_cmd_valid && !dsp_cmd_ack && !init_w |=> dsp_cmd_valid && $stable(dsp_cmd_vec));

  assert_cmd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_cmd_valid && dsp_cmd_ack |=> !dsp_cmd_valid);

  assert_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_w |=> !dsp_tx_valid && !dsp_cmd_valid && dsp_rx_ready);
endmodule

bind hostcop_mailbox hostcop_mailbox_chk #(.WORD_W(WORD_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_irq(host_irq),
  .rx_ie(rx_ie), .txh_full(txh_full), .dsp_tx_valid(dsp_tx_valid),
  .dsp_tx_ready(dsp_tx_ready), .dsp_tx_data(dsp_tx_data),
  .dsp_rx_valid(dsp_rx_valid), .dsp_rx_ready(dsp_rx_ready),
  .dsp_cmd_valid(dsp_cmd_valid), .dsp_cmd_vec(dsp_cmd_vec),
  .dsp_cmd_ack(dsp_cmd_ack)
);

// File: tb/hostcop_mailbox_tb_top.sv
`timescale 1ns/1ps
module hostcop_mailbox_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_cs = 0, host_we = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, irq_vector;
  logic host_irq;
  logic [1:0] host_flags_out, host_mode, dsp_flags_in = 0;
  logic dsp_tx_valid, dsp_tx_ready = 0, dsp_rx_valid = 0, dsp_rx_ready;
  logic [31:0] dsp_tx_data, dsp_rx_data = 0;
  logic dsp_cmd_valid, dsp_cmd_ack = 0;
  logic [4:0] dsp_cmd_vec;
  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  hostcop_mailbox dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_we = 0;
  endtask

  task automatic hr(logic [2:0] a, output logic [7:0] d);
    host_cs = 1; host_we = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_cs = 0;
  endtask

  task automatic push_rx(logic [31:0] w);
    @(negedge clk);
    dsp_rx_valid = 1; dsp_rx_data = w;
    @(negedge clk);
    dsp_rx_valid = 0;
  endtask

  task automatic take_tx();
    @(negedge clk);
    dsp_tx_ready = 1;
    @(negedge clk);
    dsp_tx_ready = 0;
  endtask

  task automatic send_word(logic [31:0] w);
    hw(4, w[31:24]); hw(5, w[23:16]); hw(6, w[15:8]); hw(7, w[7:0]);
  endtask

  task automatic t_reset();
    hr(0, rv); check("R1 ctrl", rv, 8'h00);
    hr(1, rv); check("R1 cmd", rv, 8'h00);
    hr(2, rv); check("R1 status", rv, 8'h06);
    hr(3, rv); check("R1 vector", rv, 8'h0F);
    check("R1 irq", host_irq, 0);
    check("R1 tx_valid", dsp_tx_valid, 0);
    check("R1 rx_ready", dsp_rx_ready, 1);
  endtask

  task automatic t_tx();
    hw(4, 8'h11); hw(5, 8'h22); hw(6, 8'h33);
    hr(2, rv); check("R2 upper bytes keep status", rv, 8'h06);
    hw(7, 8'h44);
    hr(2, rv); check("R2 commit clears empty", rv, 8'h00);
    hr(2, rv); check("R3 empty set, not ready", rv, 8'h02);
    check("R2 tx_valid", dsp_tx_valid, 1);
    check("R2 tx_data order", dsp_tx_data, 32'h11223344);
    @(negedge clk); @(negedge clk);
    check("R3 hold without ready", dsp_tx_data, 32'h11223344);
    take_tx();
    check("R3 taken", dsp_tx_valid, 0);
    hr(2, rv); check("R3 idle status", rv, 8'h06);
  endtask

  task automatic t_tx_b2b();
    send_word(32'hA0A1A2A3);
    send_word(32'hB0B1B2B3);
    hr(2, rv); check("R3 both full", rv, 8'h00);
    hr(2, rv); check("R3 still full", rv, 8'h00);
    check("R3 first word held", dsp_tx_data, 32'hA0A1A2A3);
    take_tx();
    check("R3 second moved on take", dsp_tx_data, 32'hB0B1B2B3);
    check("R3 second valid", dsp_tx_valid, 1);
    hr(2, rv); check("R3 empty after move", rv, 8'h02);
    take_tx();
  endtask

  task automatic t_rx();
    push_rx(32'hA1B2C3D4);
    check("R4 rx_ready low", dsp_rx_ready, 0);
    push_rx(32'h55667788);
    hr(2, rv); check("R4 full status", rv, 8'h07);
    hr(4, rv); check("R4 byte4 (ignored second)", rv, 8'hA1);
    hr(5, rv); check("R4 byte5", rv, 8'hB2);
    hr(6, rv); check("R4 byte6", rv, 8'hC3);
    hr(2, rv); check("R5 upper reads keep full", rv, 8'h07);
    hr(7, rv); check("R4 byte7", rv, 8'hD4);
    hr(2, rv); check("R5 read7 clears", rv, 8'h06);
    check("R5 rx_ready back", dsp_rx_ready, 1);
  endtask

  task automatic t_irq();
    hw(0, 8'h02);
    check("R6 tx request", host_irq, 1);
    hr(2, rv); check("R6 status bit7", rv, 8'h86);
    hw(0, 8'h01);
    check("R6 rx enable, empty", host_irq, 0);
    push_rx(32'h01020304);
    check("R6 rx request", host_irq, 1);
    hr(7, rv);
    check("R6 rx request drops", host_irq, 0);
    hw(0, 8'h00);
  endtask

  task automatic t_flags();
    dsp_flags_in = 2'b10;
    hw(0, 8'h18);
    check("R7 flags out", host_flags_out, 2'b11);
    hr(2, rv); check("R7 flags in", rv, 8'h16);
    hw(0, 8'h40);
    check("R8 mode", host_mode, 2'b10);
    check("R7 flags out cleared", host_flags_out, 2'b00);
    hr(2, rv); check("R8 mode indicator", rv, 8'h56);
    hr(0, rv); check("R8 ctrl readback", rv, 8'h40);
    hw(0, 8'h00);
    hr(2, rv); check("R8 indicator off", rv, 8'h16);
    dsp_flags_in = 2'b00;
  endtask

  task automatic t_cmd();
    hw(1, 8'h93);
    check("R9 cmd valid", dsp_cmd_valid, 1);
    check("R9 cmd vec", dsp_cmd_vec, 5'h13);
    hr(1, rv); check("R9 cmd read", rv, 8'h93);
    hw(1, 8'h85);
    hr(1, rv); check("R9 write while pending ignored", rv, 8'h93);
    @(negedge clk); dsp_cmd_ack = 1;
    @(negedge clk); dsp_cmd_ack = 0;
    check("R9 self clear", dsp_cmd_valid, 0);
    hr(1, rv); check("R9 vector kept", rv, 8'h13);
    hw(1, 8'h07);
    hr(1, rv); check("R9 bit7 clear ignored", rv, 8'h13);
  endtask

  task automatic t_init();
    send_word(32'hCAFEF00D);
    send_word(32'h12345678);
    push_rx(32'hDEADBEEF);
    hw(1, 8'h8A);
    hr(2, rv); check("R10 busy before", rv, 8'h01);
    hw(0, 8'h80);
    hr(0, rv); check("R10 init reads 0", rv, 8'h00);
    hr(2, rv); check("R10 status cleared", rv, 8'h06);
    check("R10 tx_valid", dsp_tx_valid, 0);
    check("R10 cmd_valid", dsp_cmd_valid, 0);
    check("R10 rx_ready", dsp_rx_ready, 1);
  endtask

  task automatic t_vec();
    hw(3, 8'h5A);
    hr(3, rv); check("R11 readback", rv, 8'h5A);
    check("R11 port", irq_vector, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_tx_b2b();
    t_rx();
    t_irq();
    t_flags();
    t_cmd();
    t_init();
    t_vec();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule